// File: doc/BRIEF.md
# Configuration-gating JTAG test access port

This block is a four-wire test access port that streams a serial configuration bitstream into a device's configuration memory. It also decides which scan instructions may run at each point of the configuration life cycle. The standard sixteen-state controller is clocked by `tck` and steered by `tms`. A 10-bit instruction register selects one data register between `tdi` and `tdo`. The program instruction turns the scan path into a one-bit pipe whose input bit is also presented to configuration memory as `cfg_bit` with `cfg_bit_vld`.

A configuration sequencer tracks five phases: blank, loading, initializing, user and aborted. Once the expected number of bitstream bits has been shifted, a fixed number of further `tck` cycles must elapse before `cfg_done` rises. While loading or initializing, only the non-intrusive instructions are honoured. The I/O-override instruction aborts configuration and lets a host write an I/O control word. After an abort the device remains unconfigured until the pulse-reconfigure instruction runs or `reconfig_n` is taken low and released. The chip-wide clear and output-enable inputs reach only the sample register.

Top module: `cfg_tap`

## Requirements
- R1: `rst_n` low, or five consecutive `tck` cycles with `tms` high, puts the controller in Test-Logic-Reset. That state selects IDCODE. While `rst_n` is low, `cfg_done`, `cfg_bit_vld` and `tdo` are 0.
- R2: Capture-IR loads binary ...01, so the first two bits shifted out of the instruction register are 1 then 0. BYPASS (opcode all ones, also used for any unknown opcode) is a 1-bit register that captures 0.
- R3: IDCODE (opcode 0x006) is a 32-bit register, shifted out LSB first, that captures 0x1C0DE0A3 (bit 0 set).
- R4: Under the program instruction (opcode 0x0A2), each bit shifted in on `tdi` appears on `tdo` one `tck` cycle later. The first bit out is 0.
- R5: `cfg_bit_vld` is high, with `cfg_bit` equal to `tdi`, exactly in the Shift-DR cycles under the program instruction while the device is blank or loading and `reconfig_n` is high. The count of such bits runs across separate scans.
- R6: After the 64th bitstream bit, `cfg_done` rises on the 299th following `tck` edge, and not earlier.
- R7: While loading or initializing, BYPASS, IDCODE and SAMPLE operate normally and leave the bit count and the initialization count unchanged.
- R8: While loading or initializing, an Update-IR with any other opcode except program and I/O override (for example pulse-reconfigure, 0x0E1) acts as BYPASS and has no effect on configuration.
- R9: Loading the I/O-override instruction (0x0C3) in any phase aborts configuration and clears `cfg_done`. Its 8-bit data register is written to `io_ctl` at Update-DR. After the abort, program shifts assert no `cfg_bit_vld` and `cfg_done` stays low.
- R10: From the aborted or user phase, pulse-reconfigure, or `reconfig_n` low and released, returns the device to blank so that a full new bitstream configures it.
- R11: `reconfig_n` low at a `tck` edge clears `cfg_done` and returns the device to blank at that edge.
- R12: SAMPLE (opcode 0x005) is a 4-bit register that captures {`cfg_done`, `reconfig_n`, `chip_oe`, `chip_clr_n`}, bit 3 down to bit 0. This makes `cfg_done` readable over the scan port.
- R13: Toggling `chip_clr_n` and `chip_oe` has no effect on the controller, the bit stream or `cfg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, 0 outside the shift states |
| reconfig_n | input | 1 | Reconfiguration request, active low |
| chip_clr_n | input | 1 | Chip-wide clear, sampled only |
| chip_oe | input | 1 | Chip-wide output enable, sampled only |
| cfg_done | output | 1 | Configuration complete |
| cfg_bit | output | 1 | Bitstream bit to configuration memory |
| cfg_bit_vld | output | 1 | `cfg_bit` is a counted bitstream bit this cycle |
| io_ctl | output | 8 | I/O control word written under I/O override |

## Verification
`tdo` and `cfg_bit_vld` are combinational on the current controller state, so the bench samples them at the falling edge inside the cycle whose rising edge would shift the bit. A shifted-in bit therefore shows on `tdo` one sample later. `cfg_done`, the phase and `io_ctl` change on a rising edge, so the bench reads them 1 ns after that edge. The reference model advances its bit and initialization counts on the same edge. The 299-cycle window is probed at edge 298, where `cfg_done` must still be low, and at edge 299, where it must be high. These edges are counted from the last Shift-DR edge and include the Exit1 and Update edges that end the scan.

// File: rtl/cfg_tap.sv
module cfg_tap #(
  parameter int IR_W     = 10,
  parameter int ID_W     = 32,
  parameter int IO_W     = 8,
  parameter int BITS     = 64,
  parameter int INIT_CYC = 299,
  parameter logic [ID_W-1:0] ID_VAL    = 32'h1C0D_E0A3,
  parameter logic [IR_W-1:0] OP_IDCODE = 10'h006,
  parameter logic [IR_W-1:0] OP_SAMPLE = 10'h005,
  parameter logic [IR_W-1:0] OP_PROG   = 10'h0A2,
  parameter logic [IR_W-1:0] OP_IOCTL  = 10'h0C3,
  parameter logic [IR_W-1:0] OP_PULSE  = 10'h0E1
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  input  logic            reconfig_n,
  input  logic            chip_clr_n,
  input  logic            chip_oe,
  output logic            cfg_done,
  output logic            cfg_bit,
  output logic            cfg_bit_vld,
  output logic [IO_W-1:0] io_ctl
);
  localparam logic [IR_W-1:0] OP_BYP = {IR_W{1'b1}};
  localparam int SMP_W = 4;
  localparam int DR_W  = (ID_W > IO_W) ? ((ID_W > SMP_W) ? ID_W : SMP_W) : ((IO_W > SMP_W) ? IO_W : SMP_W);
  localparam int LW    = (DR_W > 1) ? $clog2(DR_W) : 1;
  localparam int CMAX  = (BITS > INIT_CYC) ? BITS : INIT_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    TLR = 4'd0, RTI = 4'd1, SDR = 4'd2, CDR = 4'd3, SHDR = 4'd4, E1DR = 4'd5, PDR = 4'd6, E2DR = 4'd7,
    UDR = 4'd8, SIR = 4'd9, CIR = 4'd10, SHIR = 4'd11, E1IR = 4'd12, PIR = 4'd13, E2IR = 4'd14, UIR = 4'd15
  } tap_t;
  typedef enum logic [2:0] {BLANK = 3'd0, LOADING = 3'd1, INITG = 3'd2, USER = 3'd3, ABORTED = 3'd4} ph_t;

  tap_t tap, tap_n;
  ph_t  st;
  logic [IR_W-1:0] ir, ir_sr, ir_new;
  logic [DR_W-1:0] dr, dr_sh, cap;
  logic [LW-1:0]   lsel;
  logic [CW-1:0]   cnt;
  logic busy, ok_op, prog_sh;

  always_comb begin
    case (tap)
      TLR:     tap_n = tms ? TLR  : RTI;
      RTI:     tap_n = tms ? SDR  : RTI;
      SDR:     tap_n = tms ? SIR  : CDR;
      CDR:     tap_n = tms ? E1DR : SHDR;
      SHDR:    tap_n = tms ? E1DR : SHDR;
      E1DR:    tap_n = tms ? UDR  : PDR;
      PDR:     tap_n = tms ? E2DR : PDR;
      E2DR:    tap_n = tms ? UDR  : SHDR;
      UDR:     tap_n = tms ? SDR  : RTI;
      SIR:     tap_n = tms ? TLR  : CIR;
      CIR:     tap_n = tms ? E1IR : SHIR;
      SHIR:    tap_n = tms ? E1IR : SHIR;
      E1IR:    tap_n = tms ? UIR  : PIR;
      PIR:     tap_n = tms ? E2IR : PIR;
      E2IR:    tap_n = tms ? UIR  : SHIR;
      default: tap_n = tms ? SDR  : RTI;
    endcase
  end

  assign busy    = (st == LOADING) || (st == INITG);
  assign ok_op   = (ir_sr == OP_BYP) || (ir_sr == OP_IDCODE) || (ir_sr == OP_SAMPLE) ||
                   (ir_sr == OP_PROG) || (ir_sr == OP_IOCTL);
  assign ir_new  = (busy && !ok_op) ? OP_BYP : ir_sr;
  assign prog_sh = (tap == SHDR) && (ir == OP_PROG);

  always_comb begin
    cap = '0;
    if (ir == OP_IDCODE) begin
      lsel = LW'(ID_W - 1);
      cap[ID_W-1:0] = ID_VAL;
    end else if (ir == OP_SAMPLE) begin
      lsel = LW'(SMP_W - 1);
      cap[SMP_W-1:0] = {cfg_done, reconfig_n, chip_oe, chip_clr_n};
    end else if (ir == OP_IOCTL) begin
      lsel = LW'(IO_W - 1);
      cap[IO_W-1:0] = io_ctl;
    end else begin
      lsel = '0;
    end
    dr_sh = dr >> 1;
    dr_sh[lsel] = tdi;
  end

  assign tdo         = (tap == SHDR) ? dr[0] : ((tap == SHIR) ? ir_sr[0] : 1'b0);
  assign cfg_bit     = tdi;
  assign cfg_bit_vld = prog_sh && reconfig_n && ((st == BLANK) || (st == LOADING));

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tap    <= TLR;
      ir     <= OP_IDCODE;
      ir_sr  <= '0;
      dr     <= '0;
      io_ctl <= '0;
    end else begin
      tap <= tap_n;
      if (tap == TLR) ir <= OP_IDCODE;
      if (tap == CIR) ir_sr <= IR_W'(2'b01);
      if (tap == SHIR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (tap == UIR) ir <= ir_new;
      if (tap == CDR) dr <= cap;
      if (tap == SHDR) dr <= dr_sh;
      if (tap == UDR && ir == OP_IOCTL) io_ctl <= dr[IO_W-1:0];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      st       <= BLANK;
      cnt      <= '0;
      cfg_done <= 1'b0;
    end else if (!reconfig_n) begin
      st       <= BLANK;
      cnt      <= '0;
      cfg_done <= 1'b0;
    end else if (tap == UIR && ir_new == OP_IOCTL) begin
      st       <= ABORTED;
      cfg_done <= 1'b0;
    end else if (tap == UIR && ir_new == OP_PULSE) begin
      st       <= BLANK;
      cnt      <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_bit_vld) begin
      if (cnt == CW'(BITS - 1)) begin
        st  <= INITG;
        cnt <= '0;
      end else begin
        st  <= LOADING;
        cnt <= cnt + 1'b1;
      end
    end else if (st == INITG) begin
      if (cnt == CW'(INIT_CYC - 1)) begin
        st       <= USER;
        cfg_done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_tap_chk.sv
module cfg_tap_chk (
  input logic       tck,
  input logic       rst_n,
  input logic       tms,
  input logic       tdi,
  input logic       tdo,
  input logic       reconfig_n,
  input logic       cfg_done,
  input logic       cfg_bit_vld,
  input logic [2:0] st,
  input logic [3:0] tap,
  input logic       prog_sh
);
  // R1
  tlr_force_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) |=> tap == 4'd0);
  // R4
  prog_echo_chk: assert property (@(posedge tck) disable iff (!rst_n)
    prog_sh && $past(prog_sh) |-> tdo == $past(tdi));
  // R5
  vld_not_done_chk: assert property (@(posedge tck) disable iff (!rst_n)
    cfg_bit_vld |-> !cfg_done);
  // R6
  done_from_init_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(st) == 3'd2);
  // R9
  abort_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    st == 3'd4 |-> !cfg_bit_vld && !cfg_done);
  // R11
  reconfig_clr_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !reconfig_n |=> !cfg_done && st == 3'd0);
endmodule

bind cfg_tap cfg_tap_chk u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .reconfig_n(reconfig_n),
  .cfg_done(cfg_done), .cfg_bit_vld(cfg_bit_vld), .st(st), .tap(tap), .prog_sh(prog_sh)
);

// File: tb/sim_cfg_tap.sv
module sim_cfg_tap;
  localparam int BITS = 64, INIT_CYC = 299;
  localparam logic [9:0] OP_BYP = 10'h3FF, OP_ID = 10'h006, OP_SMP = 10'h005,
                         OP_PROG = 10'h0A2, OP_IOC = 10'h0C3, OP_PUL = 10'h0E1;
  localparam logic [31:0] ID_VAL = 32'h1C0D_E0A3;

  logic tck = 0, rst_n = 0, tms = 1, tdi = 0, reconfig_n = 1, chip_clr_n = 1, chip_oe = 1;
  logic tdo, cfg_done, cfg_bit, cfg_bit_vld;
  logic [7:0] io_ctl;

  cfg_tap #(.BITS(BITS), .INIT_CYC(INIT_CYC)) u0 (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .reconfig_n(reconfig_n),
    .chip_clr_n(chip_clr_n), .chip_oe(chip_oe), .cfg_done(cfg_done), .cfg_bit(cfg_bit),
    .cfg_bit_vld(cfg_bit_vld), .io_ctl(io_ctl));

  always #4 tck = ~tck;

  int checks = 0, fails = 0;
  int m_st = 0, m_cnt = 0;
  bit m_done = 0, wiggle = 0;
  logic [9:0] cur_ir = OP_ID, pend_op = OP_BYP;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit allowed(input logic [9:0] op);
    return op == OP_BYP || op == OP_ID || op == OP_SMP || op == OP_PROG || op == OP_IOC;
  endfunction

  // one tck cycle; model of phase, bit count and done advanced per edge
  task automatic clk(input logic tms_v, input logic tdi_v, input bit shdr, input bit uir, output logic tdo_s);
    bit ev, busy;
    logic [9:0] nop;
    tms = tms_v; tdi = tdi_v;
    if (wiggle) begin chip_clr_n = ~chip_clr_n; chip_oe = ~chip_oe; end
    @(negedge tck);
    tdo_s = tdo;
    ev = reconfig_n && shdr && cur_ir == OP_PROG && m_st <= 1;
    chk(cfg_bit_vld === ev, "R5 vld", 64'(cfg_bit_vld), 64'(ev));
    if (ev) chk(cfg_bit === tdi_v, "R5 bit", 64'(cfg_bit), 64'(tdi_v));
    @(posedge tck); #1;
    busy = (m_st == 1 || m_st == 2);
    nop = (busy && !allowed(pend_op)) ? OP_BYP : pend_op;
    if (!reconfig_n) begin m_st = 0; m_cnt = 0; m_done = 0; end
    else if (uir && nop == OP_IOC) begin m_st = 4; m_done = 0; end
    else if (uir && nop == OP_PUL) begin m_st = 0; m_cnt = 0; m_done = 0; end
    else if (ev) begin
      m_st = 1; m_cnt++;
      if (m_cnt == BITS) begin m_st = 2; m_cnt = 0; end
    end else if (m_st == 2) begin
      m_cnt++;
      if (m_cnt == INIT_CYC) begin m_st = 3; m_done = 1; end
    end
    if (uir) cur_ir = nop;
    chk(cfg_done === m_done, "R6 done", 64'(cfg_done), 64'(m_done));
  endtask

  task automatic idle(input int n);
    logic t;
    for (int i = 0; i < n; i++) clk(0, 0, 0, 0, t);
  endtask

  task automatic reset_tap();
    logic t;
    for (int i = 0; i < 5; i++) clk(1, 0, 0, 0, t);
    clk(0, 0, 0, 0, t);
    cur_ir = OP_ID;
  endtask

  task automatic load_ir(input logic [9:0] op, output logic [9:0] capo);
    logic t;
    clk(1, 0, 0, 0, t); clk(1, 0, 0, 0, t); clk(0, 0, 0, 0, t); clk(0, 0, 0, 0, t);
    for (int i = 0; i < 10; i++) begin clk(i == 9, op[i], 0, 0, t); capo[i] = t; end
    clk(1, 0, 0, 0, t);
    pend_op = op;
    clk(0, 0, 0, 1, t);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic t;
    dout = '0;
    clk(1, 0, 0, 0, t); clk(0, 0, 0, 0, t); clk(0, 0, 0, 0, t);
    for (int i = 0; i < n; i++) begin clk(i == n - 1, din[i], 1, 0, t); dout[i] = t; end
    clk(1, 0, 0, 0, t); clk(0, 0, 0, 0, t);
  endtask

  task automatic echo_chk(input string req, input int n, input logic [63:0] din, input logic [63:0] dout);
    logic [63:0] e;
    e = din << 1;
    if (n < 64) e = e & ((64'd1 << n) - 1);
    chk(dout === e, req, dout, e);
  endtask

  task automatic prog(input int n, input logic [63:0] din, input string req);
    logic [9:0] c;
    logic [63:0] o;
    load_ir(OP_PROG, c);
    scan_dr(n, din, o);
    echo_chk(req, n, din, o);
  endtask

  task automatic pulse_reconfig();
    reconfig_n = 0;
    idle(2);
    chk(cfg_done === 1'b0, "R11 done low", 64'(cfg_done), 0);
    reconfig_n = 1;
    idle(1);
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] c;
    logic [63:0] o;
    repeat (3) @(posedge tck);
    #1;
    chk(cfg_done === 0 && tdo === 0 && cfg_bit_vld === 0, "R1 reset outputs",
        {61'd0, cfg_done, tdo, cfg_bit_vld}, 0);
    rst_n = 1;
    idle(2);
    scan_dr(32, 0, o);
    chk(o[31:0] === ID_VAL, "R1 idcode after reset", o, 64'(ID_VAL));
    load_ir(OP_BYP, c);
    reset_tap();
    scan_dr(32, 0, o);
    chk(o[31:0] === ID_VAL && o[0] === 1'b1, "R3 idcode after tms reset", o, 64'(ID_VAL));
    load_ir(OP_BYP, c);
    chk(c[1:0] === 2'b01, "R2 ir capture", 64'(c[1:0]), 1);
    scan_dr(8, 64'hB3, o);
    echo_chk("R2 bypass", 8, 64'hB3, o);
    chip_oe = 1; chip_clr_n = 0;
    load_ir(OP_SMP, c);
    scan_dr(4, 0, o);
    chk(o[3:0] === 4'b0110, "R12 sample blank", 64'(o[3:0]), 64'h6);
    chip_clr_n = 1;

    // first bitstream, split by non-intrusive and ignored instructions
    wiggle = 1;
    prog(32, 64'hDEAD_BEEF, "R4 echo part1");
    load_ir(OP_ID, c);
    scan_dr(32, 0, o);
    chk(o[31:0] === ID_VAL, "R7 idcode during load", o, 64'(ID_VAL));
    load_ir(OP_PUL, c);
    scan_dr(4, 64'h5, o);
    echo_chk("R8 pulse acts as bypass", 4, 64'h5, o);
    chk(m_st == 1, "R8 phase kept", 64'(m_st), 1);
    load_ir(OP_SMP, c);
    scan_dr(4, 0, o);
    chk(o[3] === 1'b0, "R7 sample during load", 64'(o[3]), 0);
    prog(32, 64'h1234_5678, "R4 echo part2");
    wiggle = 0;
    idle(296);
    chk(cfg_done === 1'b0, "R6 edge 298", 64'(cfg_done), 0);
    idle(1);
    chk(cfg_done === 1'b1, "R6 edge 299", 64'(cfg_done), 1);
    chk(cfg_done === 1'b1, "R13 chip pins had no effect", 64'(cfg_done), 1);
    load_ir(OP_SMP, c);
    scan_dr(4, 0, o);
    chk(o[3] === 1'b1, "R12 sample done", 64'(o[3]), 1);
    prog(8, 64'hA5, "R5 user mode program");

    pulse_reconfig();
    chk(cfg_done === 1'b0, "R11 cleared", 64'(cfg_done), 0);

    prog(20, 64'hF0F0F, "R4 echo partial");
    load_ir(OP_IOC, c);
    chk(cfg_done === 1'b0 && m_st == 4, "R9 aborted", 64'(cfg_done), 0);
    scan_dr(8, 64'h5A, o);
    chk(io_ctl === 8'h5A, "R9 io write", 64'(io_ctl), 64'h5A);
    prog(64, 64'h0123_4567_89AB_CDEF, "R4 echo aborted");
    idle(310);
    chk(cfg_done === 1'b0, "R9 stays unconfigured", 64'(cfg_done), 0);

    load_ir(OP_PUL, c);
    chk(m_st == 0, "R10 pulse to blank", 64'(m_st), 0);
    prog(64, 64'hFEDC_BA98_7654_3210, "R4 echo reload");
    idle(297);
    chk(cfg_done === 1'b1, "R10 reconfigured by pulse", 64'(cfg_done), 1);

    load_ir(OP_IOC, c);
    chk(cfg_done === 1'b0, "R9 abort from user", 64'(cfg_done), 0);
    pulse_reconfig();
    wiggle = 1;
    prog(64, 64'h0F1E_2D3C_4B5A_6978, "R13 echo with pin toggles");
    idle(297);
    wiggle = 0;
    chk(cfg_done === 1'b1, "R10 reconfigured by reconfig_n", 64'(cfg_done), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule